// File: doc/BRIEF.md
# Memory Chip-Select Decoder

This block looks at the 20-bit memory address of each bus cycle and drives two active-low chip selects. One covers a window that always ends at the top of the 1 Mbyte space. The other covers a window that always starts at address zero. A 16-bit configuration register controls each window. Bits [15:6] hold the window boundary in 1 Kbyte blocks. Bits [1:0] hold the number of wait states. Bit 2 decides whether the cycle ignores the external ready input or waits for it.

The processor pulses `bus_strobe` for one clock with a valid address. The block then registers the matching chip select and holds it until the cycle completes. It marks completion with a single-cycle `cyc_done` pulse. Completion needs two things: the programmed wait states must have elapsed, and, when the window honours ready, `ext_rdy` must be sampled high. An address that hits neither window asserts no select. Such a cycle ends on the first ready after zero wait states.

Top module: `mem_csel_decoder`

## Requirements
- R1: After reset both selects are high (inactive) and `cyc_done` is low. The upper register value is FFFBh: it covers FFC00h–FFFFFh with 3 wait states and ready honoured. The lower select never asserts until the lower register has been written once.
- R2: The upper select asserts when address bits [19:10] are greater than or equal to upper register bits [15:6]. For example, writing E005h gives a 128 Kbyte window starting at E0000h.
- R3: Once enabled, the lower select asserts when address bits [19:10] are less than or equal to lower register bits [15:6]. For example, writing 07C4h covers 00000h–07FFFh.
- R4: Every write to the upper register is ORed with C038h, and every write to the lower register is ORed with 0038h. Writing 0000h to the upper register therefore gives a window starting at C0000h with 0 wait states and ready honoured.
- R5: With N wait states (register bits [1:0]) and ready ignored, the select is low for exactly N+1 clock cycles. `cyc_done` is high in the cycle right after the last one.
- R6: With register bit 2 clear, the cycle ends only after the N waits have elapsed and `ext_rdy` is sampled high. Ready arriving before the waits have elapsed does not shorten the cycle.
- R7: With register bit 2 set, a low `ext_rdy` has no effect on cycle length.
- R8: When an address falls in both windows, only the upper select asserts.
- R9: An address outside both windows asserts neither select. Its cycle completes with zero wait states, once `ext_rdy` is high.
- R10: A strobe that arrives while a cycle is in progress is ignored. It neither changes the select nor restarts the count.
- R11: The two selects are never low together. `cyc_done` lasts one cycle, and both selects are high whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_lower | input | 1 | Write target: 0 upper register, 1 lower register |
| cfg_wdata | input | 16 | Configuration write data |
| bus_strobe | input | 1 | One-clock pulse marking a new bus cycle with valid address |
| bus_addr | input | 20 | Memory address of the cycle |
| ext_rdy | input | 1 | External ready |
| upper_cs_n | output | 1 | Active-low select for the top-anchored window |
| lower_cs_n | output | 1 | Active-low select for the zero-anchored window |
| cyc_done | output | 1 | One-cycle pulse when the bus cycle completes |

## Verification
Addresses are placed one 1 Kbyte block on either side of each programmed boundary. This separates an inclusive compare from an exclusive one, and shows whether the forced register bits shift the upper start. Cycles run every wait-state count with ready ignored, and then with ready arriving before, at and after the count expires. This tells a correct wait counter from one that drops the ready qualifier or lets early ready cut the cycle short. Overlapping windows, miss addresses and a strobe held high through an active cycle expose errors in priority and in the hold of the busy state.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_LOWER = 2'd2
  } sel_e;

  // bits that always read as one in each configuration register
  localparam logic [15:0] UPPER_FORCED = 16'hC038;
  localparam logic [15:0] LOWER_FORCED = 16'h0038;
  // top 1 Kbyte, 3 waits, external ready honoured
  localparam logic [15:0] UPPER_RESET  = 16'hFFFB;
endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
  import csel_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel_lower,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] upper_q,
  output logic [REG_W-1:0] lower_q,
  output logic             lower_en
);
  localparam logic [REG_W-1:0] U_OR  = REG_W'(UPPER_FORCED);
  localparam logic [REG_W-1:0] L_OR  = REG_W'(LOWER_FORCED);
  localparam logic [REG_W-1:0] U_RST = REG_W'(UPPER_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q  <= U_RST;
      lower_q  <= L_OR;
      lower_en <= 1'b0;
    end else if (we) begin
      if (sel_lower) begin
        lower_q  <= wdata | L_OR;
        lower_en <= 1'b1;
      end else begin
        upper_q  <= wdata | U_OR;
      end
    end
  end
endmodule

// File: rtl/csel_window.sv
module csel_window #(
  parameter int FLD_W        = 10,
  parameter bit TOP_ANCHORED = 1'b1
) (
  input  logic [FLD_W-1:0] blk,
  input  logic [FLD_W-1:0] bound,
  input  logic             enable,
  output logic             hit
);
  generate
    if (TOP_ANCHORED) begin : g_top
      // window runs from bound up to the last block
      assign hit = enable && (blk >= bound);
    end else begin : g_zero
      // window runs from block zero up to bound inclusive
      assign hit = enable && (blk <= bound);
    end
  endgenerate
endmodule

// File: rtl/csel_wait_ctr.sv
module csel_wait_ctr #(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WS_W-1:0] ws,
  input  logic            ign_rdy,
  input  logic            ext_rdy,
  output logic            busy,
  output logic            finish,
  output logic            done
);
  logic [WS_W-1:0] cnt;
  logic            ign_q;

  assign finish = busy && (cnt == '0) && (ign_q || ext_rdy);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      ign_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt   <= ws;
          ign_q <= ign_rdy;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_csel_decoder.sv
module mem_csel_decoder
  import csel_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BLK_BITS = 10,
  parameter int REG_W    = 16,
  parameter int WS_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_lower,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              bus_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ext_rdy,
  output logic              upper_cs_n,
  output logic              lower_cs_n,
  output logic              cyc_done
);
  localparam int FLD_W   = ADDR_W - BLK_BITS;
  localparam int FLD_LSB = REG_W - FLD_W;
  localparam int IGN_BIT = WS_W;

  logic [REG_W-1:0] upper_q, lower_q;
  logic             lower_en;
  logic [FLD_W-1:0] blk;
  logic [FLD_W-1:0] bound [2];
  logic [1:0]       win_en, win_hit;
  sel_e             sel;
  logic [WS_W-1:0]  ws_sel;
  logic             ign_sel;
  logic             busy, finish, start;
  logic             unused_cfg_bits;

  csel_cfg_regs #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .sel_lower(cfg_lower),
    .wdata    (cfg_wdata),
    .upper_q  (upper_q),
    .lower_q  (lower_q),
    .lower_en (lower_en)
  );

  assign blk      = bus_addr[ADDR_W-1:BLK_BITS];
  assign bound[0] = upper_q[REG_W-1:FLD_LSB];
  assign bound[1] = lower_q[REG_W-1:FLD_LSB];
  assign win_en   = {lower_en, 1'b1};
  assign unused_cfg_bits = ^{upper_q[FLD_LSB-1:IGN_BIT+1], lower_q[FLD_LSB-1:IGN_BIT+1]};

  generate
    for (genvar w = 0; w < 2; w++) begin : g_win
      csel_window #(.FLD_W(FLD_W), .TOP_ANCHORED(w == 0)) u_win (
        .blk   (blk),
        .bound (bound[w]),
        .enable(win_en[w]),
        .hit   (win_hit[w])
      );
    end
  endgenerate

  // upper window wins on overlap
  always_comb begin
    if (win_hit[0])      sel = SEL_UPPER;
    else if (win_hit[1]) sel = SEL_LOWER;
    else                 sel = SEL_NONE;
    case (sel)
      SEL_UPPER: begin ws_sel = upper_q[WS_W-1:0]; ign_sel = upper_q[IGN_BIT]; end
      SEL_LOWER: begin ws_sel = lower_q[WS_W-1:0]; ign_sel = lower_q[IGN_BIT]; end
      default:   begin ws_sel = '0;                ign_sel = 1'b0;            end
    endcase
  end

  assign start = bus_strobe && !busy;

  csel_wait_ctr #(.WS_W(WS_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ws     (ws_sel),
    .ign_rdy(ign_sel),
    .ext_rdy(ext_rdy),
    .busy   (busy),
    .finish (finish),
    .done   (cyc_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_cs_n <= 1'b1;
      lower_cs_n <= 1'b1;
    end else if (start) begin
      upper_cs_n <= (sel != SEL_UPPER);
      lower_cs_n <= (sel != SEL_LOWER);
    end else if (finish) begin
      upper_cs_n <= 1'b1;
      lower_cs_n <= 1'b1;
    end
  end
endmodule

// File: rtl/csel_checker.sv
module csel_checker (
  input logic clk,
  input logic rst,
  input logic bus_strobe,
  input logic upper_cs_n,
  input logic lower_cs_n,
  input logic cyc_done
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (upper_cs_n && lower_cs_n && !cyc_done));

  assert_cs_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(!upper_cs_n && !lower_cs_n));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !cyc_done);

  assert_done_releases_R11: assert property (@(posedge clk) disable iff (rst)
    cyc_done |-> (upper_cs_n && lower_cs_n));

  assert_upper_start_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(upper_cs_n) |-> $past(bus_strobe));

  assert_lower_start_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(lower_cs_n) |-> $past(bus_strobe));

  assert_upper_held_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(upper_cs_n) |-> cyc_done);

  assert_lower_held_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(lower_cs_n) |-> cyc_done);
endmodule

bind mem_csel_decoder csel_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_strobe(bus_strobe),
  .upper_cs_n(upper_cs_n),
  .lower_cs_n(lower_cs_n),
  .cyc_done  (cyc_done)
);

// File: tb/mem_csel_decoder_test.sv
module mem_csel_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_lower = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_strobe = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        ext_rdy = 1'b1;
  logic        upper_cs_n, lower_cs_n, cyc_done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mem_csel_decoder uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lower(cfg_lower),
    .cfg_wdata(cfg_wdata), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .ext_rdy(ext_rdy), .upper_cs_n(upper_cs_n), .lower_cs_n(lower_cs_n),
    .cyc_done(cyc_done)
  );

  task automatic check(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic write_reg(input bit lower, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lower = lower; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // sel: 0 none, 1 upper, 2 lower; lows = cycles a select was low;
  // done_at = negedge index where cyc_done is seen (strobe driven at index 0)
  task automatic bus_cycle(input logic [19:0] a, input int rdy_from,
                           input int exp_sel, input int exp_lows, input string tag);
    int sel = 0, lows = 0, done_at = 0, both = 0;
    @(negedge clk);
    bus_addr = a; bus_strobe = 1'b1;
    for (int k = 1; k <= 60 && done_at == 0; k++) begin
      @(negedge clk);
      if (k == 1) bus_strobe = 1'b0;
      if (!upper_cs_n && !lower_cs_n) both++;
      if (!upper_cs_n) begin sel = 1; lows++; end
      else if (!lower_cs_n) begin sel = 2; lows++; end
      if (cyc_done) done_at = k;
      ext_rdy = (k >= rdy_from);
    end
    check(sel, exp_sel, {tag, " select"});
    check(lows, exp_lows, {tag, " select low cycles"});
    check(done_at, exp_lows + 1 + (exp_sel == 0 ? (exp_lows == 0 ? (rdy_from > 1 ? rdy_from : 1) : 0) : 0),
          {tag, " done position"});
    check(both, 0, {tag, " R11 exclusive selects"});
    @(negedge clk);
    check(int'(cyc_done), 0, {tag, " R11 done single cycle"});
    ext_rdy = 1'b1;
  endtask

  task automatic t_reset;
    check(int'(upper_cs_n), 1, "R1 upper idle after reset");
    check(int'(lower_cs_n), 1, "R1 lower idle after reset");
    check(int'(cyc_done), 0, "R1 done low after reset");
    bus_cycle(20'hFFC00, 0, 1, 4, "R1 default top block 3 waits");
    bus_cycle(20'hFFFFF, 6, 1, 6, "R1 default ready honoured");
    bus_cycle(20'hFFBFF, 0, 0, 0, "R1 below default window");
    bus_cycle(20'h00000, 0, 0, 0, "R1 lower disabled before write");
  endtask

  task automatic t_upper;
    write_reg(1'b0, 16'hE005);
    bus_cycle(20'hE0000, 0, 1, 2, "R2 upper start 128K");
    bus_cycle(20'hDFFFF, 0, 0, 0, "R2 just below upper start");
  endtask

  task automatic t_lower;
    write_reg(1'b1, 16'h07C4);
    bus_cycle(20'h07FFF, 0, 2, 1, "R3 lower top of 32K");
    bus_cycle(20'h08000, 0, 0, 0, "R3 just above lower end");
  endtask

  task automatic t_forced;
    write_reg(1'b0, 16'h0000);
    bus_cycle(20'hC0000, 3, 1, 3, "R4 upper forced start C0000");
    bus_cycle(20'hBFFFF, 0, 0, 0, "R4 below forced start");
    write_reg(1'b1, 16'h0000);
    bus_cycle(20'h003FF, 0, 2, 1, "R4 lower minimum 1K");
    bus_cycle(20'h00400, 0, 0, 0, "R4 past lower 1K");
  endtask

  task automatic t_waits;
    for (int w = 0; w < 4; w++) begin
      write_reg(1'b0, 16'hE004 | 16'(w));
      bus_cycle(20'hF0000, 99, 1, w + 1, $sformatf("R5 %0d waits", w));
    end
  endtask

  task automatic t_ready;
    write_reg(1'b0, 16'hE002);
    bus_cycle(20'hF0000, 0, 1, 3, "R6 ready always high");
    bus_cycle(20'hF0000, 2, 1, 3, "R6 early ready no shortening");
    bus_cycle(20'hF0000, 6, 1, 6, "R6 late ready stretches");
  endtask

  task automatic t_ignore;
    write_reg(1'b0, 16'hE006);
    bus_cycle(20'hF0000, 99, 1, 3, "R7 ready low ignored");
  endtask

  task automatic t_overlap;
    write_reg(1'b0, 16'hE005);
    write_reg(1'b1, 16'hFFC4);
    bus_cycle(20'hF0000, 0, 1, 2, "R8 upper wins overlap");
    bus_cycle(20'h10000, 0, 2, 1, "R8 lower outside upper");
  endtask

  task automatic t_miss;
    write_reg(1'b1, 16'h07C4);
    bus_cycle(20'h40000, 4, 0, 0, "R9 miss waits for ready");
  endtask

  task automatic t_busy_strobe;
    int ups = 0, lows = 0, done_at = 0;
    write_reg(1'b0, 16'hE007);
    @(negedge clk);
    bus_addr = 20'hF0000; bus_strobe = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) bus_addr = 20'h00100;
      if (!upper_cs_n) ups++;
      if (!lower_cs_n) lows++;
      if (cyc_done && done_at == 0) done_at = k;
      if (k == 4) bus_strobe = 1'b0;
    end
    check(ups, 4, "R10 upper held through strobes");
    check(lows, 0, "R10 lower not started while busy");
    check(done_at, 5, "R10 count not restarted");
    @(negedge clk);
    check(int'(upper_cs_n && lower_cs_n), 1, "R10 idle after cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_upper;
    t_lower;
    t_forced;
    t_waits;
    t_ready;
    t_ignore;
    t_overlap;
    t_miss;
    t_busy_strobe;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule